// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block paces a TFT panel. From three packed 32-bit timing words it derives horizontal sync, vertical sync, a data-enable that marks visible pixels, a one-cycle pixel clock enable and a divided pixel clock. Most interval lengths are stored in minus-one form. The two vertical porches are the exception: they are stored as raw counts and may be zero. The active width is stored in units of 16 pixels, minus one.

Every line runs through four phases in a fixed order: visible pixels, front porch, sync and back porch. Every frame runs through the same four phases, counted in lines. The timing words are sampled only when a frame begins, so a frame never mixes two sets of timing. When the enable is cleared, the current frame finishes and a one-cycle completion pulse follows. If sync-lost and FIFO underflow are flagged in the same cycle, the raster stops and restarts at once from the first pixel.

Top module: `lcd_raster_timer`

## Requirements
- R1: Horizontal decode. Visible width is ({tim2[3], tim0[9:4]} + 1) * 16 pixels. Front porch is {tim2[1:0], tim0[23:16]} + 1. Back porch is {tim2[5:4], tim0[31:24]} + 1. Sync width is {tim2[30:27], tim0[15:10]} + 1.
- R2: Vertical decode. Visible lines are {tim2[26], tim1[9:0]} + 1. Sync lines are tim1[15:10] + 1. The front porch is tim1[23:16] lines and the back porch is tim1[31:24] lines, taken as raw counts; a count of zero skips that phase.
- R3: Each line is visible, front porch, sync, back porch, in that order. `de` is high only on visible pixels of visible lines. The raw horizontal sync covers the sync pixels of every line.
- R4: Each frame is visible lines, front porch, sync, back porch, in that order. The raw vertical sync covers the whole of every sync line.
- R5: Setting tim2[12] inverts `hsync`, tim2[13] inverts `vsync` and tim2[14] inverts `pix_clk`.
- R6: `pix_ce` is high for one cycle in every D cycles, where D is `clk_div` raised to 2 when it is below 2. Raw `pix_clk` is high for the first floor(D/2) cycles of each pixel period.
- R7: Timing words and divisor are captured only at a frame start: enable from idle, wrap with the enable high, or error restart. Changes made during a frame have no effect on that frame.
- R8: In the cycle after `raster_en` is seen high in idle, pixel 0 of line 0 is output, with `de` high.
- R9: With `raster_en` low, the running frame completes. `frame_done` is then high for exactly one cycle, and the outputs go idle: `de` low and the syncs at their inactive level.
- R10: `sync_lost` and `fifo_underflow` high in the same cycle while enabled restart the frame from pixel 0 in the next cycle, with `recover` pulsed for that cycle. This takes precedence over a frame wrap in the same cycle. Either flag alone has no effect.
- R11: Both error flags in the same cycle while draining stop the raster at once, and `frame_done` pulses in the next cycle.
- R12: During reset `de`, `pix_ce`, `hsync`, `vsync`, `frame_done` and `recover` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raster_en | input | 1 | Raster run request |
| tim0 | input | 32 | Horizontal timing word |
| tim1 | input | 32 | Vertical timing word |
| tim2 | input | 32 | Extension bits and polarity controls |
| clk_div | input | DIV_W | Pixel clock divisor |
| sync_lost | input | 1 | Sync-lost status flag |
| fifo_underflow | input | 1 | Pixel FIFO underflow flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_ce | output | 1 | Pixel clock enable |
| pix_clk | output | 1 | Divided pixel clock |
| frame_done | output | 1 | Frame complete after disable |
| recover | output | 1 | Error restart pulse |

## Verification
Error recovery and the end-of-frame wrap can happen in the same cycle. The bench raises both error flags on the very last cycle of a frame while the enable is still high, and changes the timing words in that same cycle. It then expects `recover` high and `frame_done` low in the next cycle, followed by a complete frame built from the new timing. A second case applies the error pair during a drain and expects an immediate `frame_done`, not a restart.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
   localparam int LEN_W = 12;
   localparam int DIV_W = 8;

   typedef enum logic [1:0] {
      PH_ACT  = 2'd0,
      PH_FP   = 2'd1,
      PH_SYNC = 2'd2,
      PH_BP   = 2'd3
   } phase_e;

   typedef struct packed {
      logic   wrap;
      phase_e nxt;
   } step_t;

   typedef struct packed {
      logic [LEN_W-1:0] h_act;
      logic [LEN_W-1:0] h_fp;
      logic [LEN_W-1:0] h_sync;
      logic [LEN_W-1:0] h_bp;
      logic [LEN_W-1:0] v_act;
      logic [LEN_W-1:0] v_fp;
      logic [LEN_W-1:0] v_sync;
      logic [LEN_W-1:0] v_bp;
      logic             inv_h;
      logic             inv_v;
      logic             inv_pclk;
      logic [DIV_W-1:0] div;
   } raster_cfg_t;

   // phase that follows p when p ends; zero-length porches are skipped
   function automatic step_t phase_step(input phase_e p, input logic fp_zero,
                                        input logic bp_zero);
      step_t s;
      s.wrap = 1'b0;
      s.nxt  = PH_ACT;
      case (p)
         PH_ACT:  s.nxt = fp_zero ? PH_SYNC : PH_FP;
         PH_FP:   s.nxt = PH_SYNC;
         PH_SYNC: begin
            s.nxt  = bp_zero ? PH_ACT : PH_BP;
            s.wrap = bp_zero;
         end
         default: begin
            s.nxt  = PH_ACT;
            s.wrap = 1'b1;
         end
      endcase
      return s;
   endfunction

   function automatic raster_cfg_t decode_cfg(input logic [31:0] w0,
                                              input logic [31:0] w1,
                                              input logic [31:0] w2,
                                              input logic [DIV_W-1:0] div_in,
                                              input logic [DIV_W-1:0] min_div);
      raster_cfg_t c;
      c.h_act    = (LEN_W'({w2[3], w0[9:4]}) + LEN_W'(1)) << 4;
      c.h_fp     = LEN_W'({w2[1:0], w0[23:16]}) + LEN_W'(1);
      c.h_bp     = LEN_W'({w2[5:4], w0[31:24]}) + LEN_W'(1);
      c.h_sync   = LEN_W'({w2[30:27], w0[15:10]}) + LEN_W'(1);
      c.v_act    = LEN_W'({w2[26], w1[9:0]}) + LEN_W'(1);
      c.v_fp     = LEN_W'(w1[23:16]);
      c.v_bp     = LEN_W'(w1[31:24]);
      c.v_sync   = LEN_W'(w1[15:10]) + LEN_W'(1);
      c.inv_h    = w2[12];
      c.inv_v    = w2[13];
      c.inv_pclk = w2[14];
      c.div      = (div_in < min_div) ? min_div : div_in;
      return c;
   endfunction
endpackage

// File: rtl/lrt_pix_div.sv
module lrt_pix_div
   import lrt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             ce,
   output logic             pclk_raw
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_top;

   assign at_top   = (cnt_q == div - DIV_W'(1));
   assign ce       = run & at_top;
   assign pclk_raw = run & (cnt_q < (div >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || restart || at_top) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/lrt_phase_seq.sv
module lrt_phase_seq
   import lrt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [LEN_W-1:0] len_act,
   input  logic [LEN_W-1:0] len_fp,
   input  logic [LEN_W-1:0] len_sync,
   input  logic [LEN_W-1:0] len_bp,
   output phase_e           phase,
   output logic             wrap
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] cur_len;
   phase_e           ph_q;
   step_t            st;
   logic             last;

   always_comb begin
      case (ph_q)
         PH_ACT:  cur_len = len_act;
         PH_FP:   cur_len = len_fp;
         PH_SYNC: cur_len = len_sync;
         default: cur_len = len_bp;
      endcase
   end

   assign last  = (cnt_q == cur_len - LEN_W'(1));
   assign st    = phase_step(ph_q, len_fp == '0, len_bp == '0);
   assign wrap  = adv & last & st.wrap;
   assign phase = ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_ACT;
         cnt_q <= '0;
      end else if (restart) begin
         ph_q  <= PH_ACT;
         cnt_q <= '0;
      end else if (adv) begin
         if (last) begin
            ph_q  <= st.nxt;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lrt_pkg::*;
#(
   parameter int MIN_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raster_en,
   input  logic [31:0]      tim0,
   input  logic [31:0]      tim1,
   input  logic [31:0]      tim2,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             sync_lost,
   input  logic             fifo_underflow,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             pix_ce,
   output logic             pix_clk,
   output logic             frame_done,
   output logic             recover
);
   localparam logic [DIV_W-1:0] MIN_DIV_V = DIV_W'(MIN_DIV);

   generate
      if (MIN_DIV < 2 || MIN_DIV >= (1 << DIV_W)) begin : g_bad_min_div
         $error("MIN_DIV must be at least 2 and fit in DIV_W bits");
      end
      if (LEN_W < 12) begin : g_bad_len_w
         $error("LEN_W must hold 2048");
      end
   endgenerate

   raster_cfg_t cfg_q;
   raster_cfg_t cfg_new;
   logic        run_q, frame_done_q, recover_q;
   logic        err, err_restart, start_go, latch, seq_restart, frame_end;
   logic        h_wrap, pclk_raw, hs_raw, vs_raw;
   phase_e      h_ph, v_ph;
   logic        unused_bits;

   assign unused_bits = ^{tim0[3:0], tim2[31], tim2[25:15], tim2[11:6], tim2[2]};
   assign cfg_new     = decode_cfg(tim0, tim1, tim2, clk_div, MIN_DIV_V);

   assign err         = sync_lost & fifo_underflow;
   assign start_go    = ~run_q & raster_en;
   assign err_restart = run_q & raster_en & err;
   assign latch       = start_go | (run_q & raster_en & (err | frame_end));
   assign seq_restart = ~run_q | err_restart;

   lrt_pix_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .restart  (seq_restart),
      .div      (cfg_q.div),
      .ce       (pix_ce),
      .pclk_raw (pclk_raw)
   );

   lrt_phase_seq u_hseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (seq_restart),
      .adv      (pix_ce),
      .len_act  (cfg_q.h_act),
      .len_fp   (cfg_q.h_fp),
      .len_sync (cfg_q.h_sync),
      .len_bp   (cfg_q.h_bp),
      .phase    (h_ph),
      .wrap     (h_wrap)
   );

   lrt_phase_seq u_vseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (seq_restart),
      .adv      (h_wrap),
      .len_act  (cfg_q.v_act),
      .len_fp   (cfg_q.v_fp),
      .len_sync (cfg_q.v_sync),
      .len_bp   (cfg_q.v_bp),
      .phase    (v_ph),
      .wrap     (frame_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q        <= '0;
         run_q        <= 1'b0;
         frame_done_q <= 1'b0;
         recover_q    <= 1'b0;
      end else begin
         if (latch) cfg_q <= cfg_new;
         if (!run_q)
            run_q <= raster_en;
         else if (err || frame_end)
            run_q <= raster_en;
         frame_done_q <= run_q & ~raster_en & (err | frame_end);
         recover_q    <= err_restart;
      end
   end

   assign de         = run_q & (h_ph == PH_ACT) & (v_ph == PH_ACT);
   assign hs_raw     = run_q & (h_ph == PH_SYNC);
   assign vs_raw     = run_q & (v_ph == PH_SYNC);
   assign hsync      = hs_raw ^ cfg_q.inv_h;
   assign vsync      = vs_raw ^ cfg_q.inv_v;
   assign pix_clk    = pclk_raw ^ cfg_q.inv_pclk;
   assign frame_done = frame_done_q;
   assign recover    = recover_q;
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk
   import lrt_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        sync_lost,
   input logic        fifo_underflow,
   input logic        run_q,
   input logic        pix_ce,
   input logic        de,
   input logic        hs_raw,
   input logic        vs_raw,
   input logic        frame_done,
   input logic        recover,
   input raster_cfg_t cfg_q
);
   logic err_pair;
   assign err_pair = sync_lost & fifo_underflow;

   assert_ce_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ce |=> !pix_ce);

   assert_de_no_hsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !hs_raw);

   assert_de_no_vsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !vs_raw);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!de && !hs_raw && !vs_raw));

   assert_recover_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      recover |-> de);

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !pix_ce && !err_pair) |=> $stable(cfg_q));

   assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !pix_ce && !err_pair) |=> $stable({de, hs_raw, vs_raw}));
endmodule

bind lcd_raster_timer lcd_raster_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sync_lost      (sync_lost),
   .fifo_underflow (fifo_underflow),
   .run_q          (run_q),
   .pix_ce         (pix_ce),
   .de             (de),
   .hs_raw         (hs_raw),
   .vs_raw         (vs_raw),
   .frame_done     (frame_done),
   .recover        (recover),
   .cfg_q          (cfg_q)
);

// File: tb/lcd_raster_timer_tb.sv
`timescale 1ns/1ps
module lcd_raster_timer_tb;
   typedef struct packed {
      logic [31:0] t0;
      logic [31:0] t1;
      logic [31:0] t2;
      logic [7:0]  dv;
   } vec_t;

   typedef struct {
      int w, hfp, hsw, hbp, ln, vfp, vsw, vbp, d;
      bit ih, iv, ip;
   } mdl_t;

   localparam int NVEC = 5;
   localparam vec_t VECS [NVEC] = '{
      '{32'h0001_0800, 32'h0001_0402, 32'h0000_0000, 8'd2},
      '{32'h0300_0010, 32'h0200_0001, 32'h0000_1000, 8'd3},
      '{32'h0100_0000, 32'h0102_0000, 32'h0800_6001, 8'd0},
      '{32'h0000_0000, 32'h0000_0000, 32'h0000_0018, 8'd4},
      '{32'h0000_0000, 32'h0000_0000, 32'h0400_0000, 8'd2}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raster_en = 1'b0;
   logic [31:0] tim0 = '0, tim1 = '0, tim2 = '0;
   logic [7:0] clk_div = 8'd2;
   logic       sync_lost = 1'b0, fifo_underflow = 1'b0;
   logic       hsync, vsync, de, pix_ce, pix_clk, frame_done, recover;

   int total = 0;
   int bad = 0;
   int e_de, e_hs, e_vs, e_ce, e_pc, e_rec;

   always #2.5 clk = ~clk;

   lcd_raster_timer u_dut (
      .clk(clk), .rst_n(rst_n), .raster_en(raster_en),
      .tim0(tim0), .tim1(tim1), .tim2(tim2), .clk_div(clk_div),
      .sync_lost(sync_lost), .fifo_underflow(fifo_underflow),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_ce(pix_ce),
      .pix_clk(pix_clk), .frame_done(frame_done), .recover(recover)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected timing from the field layout in R1, R2, R5, R6
   function automatic mdl_t mk(input vec_t v);
      mdl_t m;
      m.w   = (int'({v.t2[3], v.t0[9:4]}) + 1) * 16;
      m.hfp = int'({v.t2[1:0], v.t0[23:16]}) + 1;
      m.hbp = int'({v.t2[5:4], v.t0[31:24]}) + 1;
      m.hsw = int'({v.t2[30:27], v.t0[15:10]}) + 1;
      m.ln  = int'({v.t2[26], v.t1[9:0]}) + 1;
      m.vfp = int'(v.t1[23:16]);
      m.vbp = int'(v.t1[31:24]);
      m.vsw = int'(v.t1[15:10]) + 1;
      m.d   = (v.dv < 8'd2) ? 2 : int'(v.dv);
      m.ih  = v.t2[12];
      m.iv  = v.t2[13];
      m.ip  = v.t2[14];
      return m;
   endfunction

   function automatic int frame_cyc(input mdl_t m);
      return (m.w + m.hfp + m.hsw + m.hbp) * (m.ln + m.vfp + m.vsw + m.vbp) * m.d;
   endfunction

   task automatic apply(input vec_t v);
      tim0 = v.t0; tim1 = v.t1; tim2 = v.t2; clk_div = v.dv;
   endtask

   task automatic cmp(input mdl_t m, input int t);
      int l, p, x, y;
      bit xde, xhs, xvs, xce, xpc;
      l = m.w + m.hfp + m.hsw + m.hbp;
      p = t / m.d;
      x = p % l;
      y = p / l;
      xde = (x < m.w) && (y < m.ln);
      xhs = ((x >= m.w + m.hfp) && (x < m.w + m.hfp + m.hsw)) ^ m.ih;
      xvs = ((y >= m.ln + m.vfp) && (y < m.ln + m.vfp + m.vsw)) ^ m.iv;
      xce = (t % m.d) == m.d - 1;
      xpc = ((t % m.d) < m.d / 2) ^ m.ip;
      if (de !== xde) e_de++;
      if (hsync !== xhs) e_hs++;
      if (vsync !== xvs) e_vs++;
      if (pix_ce !== xce) e_ce++;
      if (pix_clk !== xpc) e_pc++;
      if (t > 0 && recover !== 1'b0) e_rec++;
   endtask

   // called at the sample point of pixel 0; drops the enable, scrambles config
   task automatic run_frame(input vec_t v, input bit single_err, input string tag);
      mdl_t m;
      int fc;
      m = mk(v);
      fc = frame_cyc(m);
      e_de = 0; e_hs = 0; e_vs = 0; e_ce = 0; e_pc = 0; e_rec = 0;
      for (int t = 0; t < fc; t++) begin
         cmp(m, t);
         if (t == 0) begin
            raster_en = 1'b0;
            tim0 = 32'hFFFF_FFFF; tim1 = 32'hFFFF_FFFF; tim2 = 32'hFFFF_FFFF;
            clk_div = 8'd7;
         end
         sync_lost      = single_err && (t == 10);
         fifo_underflow = single_err && (t == 20);
         @(negedge clk);
      end
      chk(e_de == 0, {tag, " R3 R1 R7 R8 de"}, e_de, 0);
      chk(e_hs == 0, {tag, " R3 R5 hsync"}, e_hs, 0);
      chk(e_vs == 0, {tag, " R4 R2 R5 vsync"}, e_vs, 0);
      chk(e_ce == 0, {tag, " R6 pix_ce"}, e_ce, 0);
      chk(e_pc == 0, {tag, " R6 R5 pix_clk"}, e_pc, 0);
      if (single_err) chk(e_rec == 0, {tag, " R10 single flag recover"}, e_rec, 0);
      chk(frame_done === 1'b1, {tag, " R9 frame_done"}, frame_done, 1);
      chk(de === 1'b0 && hsync === m.ih && vsync === m.iv, {tag, " R9 idle outputs"},
          {de, hsync, vsync}, {1'b0, m.ih, m.iv});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      mdl_t m0;
      int fc0;
      repeat (3) @(negedge clk);
      chk({de, pix_ce, hsync, vsync, frame_done, recover} === 6'b0, "R12 reset outputs",
          {de, pix_ce, hsync, vsync, frame_done, recover}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(de === 1'b0 && frame_done === 1'b0, "R12 idle after reset", de, 0);

      // table walk: one frame per vector, drained after pixel 0
      for (int i = 0; i < NVEC; i++) begin
         apply(VECS[i]);
         raster_en = 1'b1;
         @(negedge clk);
         chk(de === 1'b1, $sformatf("vec%0d R8 first pixel", i), de, 1);
         run_frame(VECS[i], 1'b0, $sformatf("vec%0d", i));
      end
      @(negedge clk);
      chk(frame_done === 1'b0, "R9 single-cycle done", frame_done, 0);

      // lone error flags have no effect
      apply(VECS[0]);
      raster_en = 1'b1;
      @(negedge clk);
      run_frame(VECS[0], 1'b1, "lone flags R10");
      @(negedge clk);

      // error pair on the last cycle of a frame, enable high, config changed
      m0 = mk(VECS[0]);
      fc0 = frame_cyc(m0);
      apply(VECS[0]);
      raster_en = 1'b1;
      @(negedge clk);
      for (int t = 0; t < fc0 - 1; t++) @(negedge clk);
      apply(VECS[1]);
      sync_lost = 1'b1;
      fifo_underflow = 1'b1;
      @(negedge clk);
      sync_lost = 1'b0;
      fifo_underflow = 1'b0;
      chk(recover === 1'b1, "R10 recover on coincident wrap", recover, 1);
      chk(frame_done === 1'b0, "R10 no done on restart", frame_done, 0);
      chk(de === 1'b1, "R10 restart at pixel 0", de, 1);
      run_frame(VECS[1], 1'b0, "after restart R10 R7");
      @(negedge clk);

      // error pair while draining
      apply(VECS[0]);
      raster_en = 1'b1;
      @(negedge clk);
      repeat (5) @(negedge clk);
      raster_en = 1'b0;
      sync_lost = 1'b1;
      fifo_underflow = 1'b1;
      @(negedge clk);
      sync_lost = 1'b0;
      fifo_underflow = 1'b0;
      chk(frame_done === 1'b1, "R11 done after drain error", frame_done, 1);
      chk(recover === 1'b0 && de === 1'b0, "R11 stopped", {recover, de}, 0);
      @(negedge clk);
      chk(pix_ce === 1'b0 && de === 1'b0, "R11 stays idle", {pix_ce, de}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule